// File: doc/BRIEF.md
# Interval-Overlap Pruning Trail

This unit sits next to the traversal state of a stackless hierarchy walker. It keeps one bit for each tree level. The bit records whether the ray's parameter intervals through the two child boxes overlapped at that level. A 1 is stored only when both children were hit and their intervals share at least one value. A 0 is stored when the intervals were disjoint, or when only one child was hit.

The trail moves in step with the walker's main postponement trail. A descent shifts it left by one level. A backtrack shifts it right by the same number of levels that the walker climbs. Pruning needs no per-node distance and no extra data in the hierarchy.

When the walker reports a confirmed hit inside the current subtree, the unit returns the main trail ANDed with the overlap trail. This drops every postponed subtree that lies wholly behind the current one. The unit also raises a clear request for the most recently postponed node register when that node's level is pruned. That level is the lowest set bit of the main trail. The outputs are combinational from the stored trail and the present inputs.

Top module: `tint_prune_unit`

## Requirements
- R1: After synchronous reset the overlap trail is all zero. A hit with an all-ones main trail then returns zero.
- R2: On a descent with both children hit, the new level bit (bit 0) is 1 when the intervals overlap. It is 0 when they are disjoint, meaning left far < right near or right far < left near. Equal endpoints count as overlap.
- R3: On a descent with only one child hit, the new level bit is 0 whatever the interval values.
- R4: A backtrack step shifts the overlap trail right by `back_levels`, filling with zeros. A shift of the full depth or more empties the trail.
- R5: `ray_start` clears the trail. When several controls are high in the same cycle, the precedence is `ray_start` first, then descent, then backtrack.
- R6: While `hit_found` is high, `trail_out` equals `trail_in` AND the overlap trail as it stood before that cycle's clock edge. While `hit_found` is low, `trail_out` equals `trail_in`.
- R7: `mrpn_clear` is 1 exactly when `hit_found` and `mrpn_valid` are both 1 and the lowest set bit of `trail_in`, ANDed with the overlap trail, is zero. This includes the case where `trail_in` is zero.
- R8: When either `hit_found` or `mrpn_valid` is 0, `mrpn_clear` is 0.
- R9: When more than DEPTH descents occur without a backtrack, bits shifted past the top level are dropped and the trail keeps only the latest DEPTH levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ray_start | input | 1 | Begin a new ray; clears the trail |
| desc_step | input | 1 | Descend one level this cycle |
| desc_both | input | 1 | Both children hit on this descent |
| t_l_near | input | TW | Left child entry parameter |
| t_l_far | input | TW | Left child exit parameter |
| t_r_near | input | TW | Right child entry parameter |
| t_r_far | input | TW | Right child exit parameter |
| back_step | input | 1 | Backtrack this cycle |
| back_levels | input | LVW | Levels climbed by the backtrack |
| trail_in | input | DEPTH | Main postponement trail |
| mrpn_valid | input | 1 | Most recently postponed node register holds a node |
| hit_found | input | 1 | Confirmed hit inside the current subtree |
| trail_out | output | DEPTH | Pruned trail (or pass-through) |
| mrpn_clear | output | 1 | Request to invalidate the postponed node register |

## Verification
The bench targets four corner cases.

Touching interval endpoints must count as overlap. A strict comparator would store 0 there and prune a subtree that might still hold a closer hit.

A descent where only one child was hit must store 0 even when the intervals overlap. A design that ignored the both-hit flag would keep bits for levels where nothing was postponed.

Backtracking by several levels, by the full depth, and with simultaneous controls checks the shift amount, the zero fill and the precedence order. An error in any of these misaligns every later pruning decision.

The clear request is checked with a main trail whose lowest set bit is pruned, one whose lowest set bit survives, and an all-zero main trail. The hit-in-the-same-cycle-as-descent case confirms that the pre-edge trail is used.

// File: rtl/tint_pkg.sv
package tint_pkg;

    // Trail update selected for one cycle, already priority-resolved
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_START = 2'd1,
        OP_DESC  = 2'd2,
        OP_BACK  = 2'd3
    } trail_op_e;

    typedef struct packed {
        logic start;
        logic desc;
        logic back;
    } step_ctl_t;

    function automatic trail_op_e resolve_op(input step_ctl_t c);
        if (c.start)     return OP_START;
        else if (c.desc) return OP_DESC;
        else if (c.back) return OP_BACK;
        else             return OP_HOLD;
    endfunction

endpackage

// File: rtl/tint_overlap_cmp.sv
module tint_overlap_cmp #(
    parameter int  TW           = 16,
    parameter bit  TOUCH_OVERLP = 1'b1
) (
    input  logic [TW-1:0] l_near,
    input  logic [TW-1:0] l_far,
    input  logic [TW-1:0] r_near,
    input  logic [TW-1:0] r_far,
    output logic          overlap
);
    logic apart;

    generate
        if (TOUCH_OVERLP) begin : g_touch_counts
            // Sharing an endpoint is treated as overlapping (conservative)
            assign apart = (l_far < r_near) || (r_far < l_near);
        end else begin : g_touch_apart
            assign apart = (l_far <= r_near) || (r_far <= l_near);
        end
    endgenerate

    assign overlap = ~apart;
endmodule

// File: rtl/tint_ovl_trail.sv
module tint_ovl_trail
    import tint_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  trail_op_e        op,
    input  logic             shift_in,
    input  logic [LVW-1:0]   levels,
    output logic [DEPTH-1:0] ovl_q
);
    logic [DEPTH-1:0] ovl_d;

    always_comb begin
        ovl_d = ovl_q;
        unique case (op)
            OP_START: ovl_d = '0;
            OP_DESC:  ovl_d = {ovl_q[DEPTH-2:0], shift_in};
            OP_BACK:  ovl_d = ovl_q >> levels;
            default:  ovl_d = ovl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ovl_q <= '0;
        else     ovl_q <= ovl_d;
    end
endmodule

// File: rtl/tint_mask_logic.sv
module tint_mask_logic #(
    parameter int DEPTH = 32
) (
    input  logic [DEPTH-1:0] main_trail,
    input  logic [DEPTH-1:0] ovl_trail,
    input  logic             hit,
    input  logic             mrpn_valid,
    output logic [DEPTH-1:0] pruned,
    output logic             mrpn_drop
);
    logic [DEPTH-1:0] low_bit;
    logic [DEPTH-1:0] kept;

    // Isolate the level of the most recently postponed node
    assign low_bit = main_trail & (~main_trail + {{(DEPTH-1){1'b0}}, 1'b1});

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_lvl
            assign kept[gi]   = main_trail[gi] & ovl_trail[gi];
            assign pruned[gi] = hit ? kept[gi] : main_trail[gi];
        end
    endgenerate

    assign mrpn_drop = hit && mrpn_valid && ((low_bit & ovl_trail) == '0);
endmodule

// File: rtl/tint_prune_unit.sv
module tint_prune_unit
    import tint_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int TW    = 16,
    parameter int LVW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ray_start,
    input  logic             desc_step,
    input  logic             desc_both,
    input  logic [TW-1:0]    t_l_near,
    input  logic [TW-1:0]    t_l_far,
    input  logic [TW-1:0]    t_r_near,
    input  logic [TW-1:0]    t_r_far,
    input  logic             back_step,
    input  logic [LVW-1:0]   back_levels,
    input  logic [DEPTH-1:0] trail_in,
    input  logic             mrpn_valid,
    input  logic             hit_found,
    output logic [DEPTH-1:0] trail_out,
    output logic             mrpn_clear
);
    step_ctl_t        ctl;
    trail_op_e        op;
    logic             ivl_overlap;
    logic             new_bit;
    logic [DEPTH-1:0] ovl_q;

    assign ctl = '{start: ray_start, desc: desc_step, back: back_step};
    assign op  = resolve_op(ctl);

    tint_overlap_cmp #(.TW(TW), .TOUCH_OVERLP(1'b1)) u_cmp (
        .l_near (t_l_near),
        .l_far  (t_l_far),
        .r_near (t_r_near),
        .r_far  (t_r_far),
        .overlap(ivl_overlap)
    );

    // A level matters only if a sibling was actually postponed there
    assign new_bit = desc_both & ivl_overlap;

    tint_ovl_trail #(.DEPTH(DEPTH), .LVW(LVW)) u_trail (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .shift_in(new_bit),
        .levels  (back_levels),
        .ovl_q   (ovl_q)
    );

    tint_mask_logic #(.DEPTH(DEPTH)) u_mask (
        .main_trail(trail_in),
        .ovl_trail (ovl_q),
        .hit       (hit_found),
        .mrpn_valid(mrpn_valid),
        .pruned    (trail_out),
        .mrpn_drop (mrpn_clear)
    );
endmodule

// File: rtl/tint_prune_checker.sv
module tint_prune_checker #(
    parameter int DEPTH = 32,
    parameter int LVW   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             ray_start,
    input logic             desc_step,
    input logic             desc_both,
    input logic             back_step,
    input logic [LVW-1:0]   back_levels,
    input logic [DEPTH-1:0] trail_in,
    input logic             mrpn_valid,
    input logic             hit_found,
    input logic [DEPTH-1:0] trail_out,
    input logic             mrpn_clear,
    input logic [DEPTH-1:0] ovl_q
);
    a_r1_reset_empty: assert property (@(posedge clk) rst |=> ovl_q == '0);

    a_r3_single_hit_zero: assert property (@(posedge clk) disable iff (rst)
        (!ray_start && desc_step && !desc_both) |=> ovl_q[0] == 1'b0);

    a_r4_backtrack_shift: assert property (@(posedge clk) disable iff (rst)
        (!ray_start && !desc_step && back_step)
            |=> ovl_q == ($past(ovl_q) >> $past(back_levels)));

    a_r5_start_clears: assert property (@(posedge clk) disable iff (rst)
        ray_start |=> ovl_q == '0);

    a_r6_subset_of_main: assert property (@(posedge clk) disable iff (rst)
        (trail_out & ~trail_in) == '0);

    a_r6_no_hit_pass: assert property (@(posedge clk) disable iff (rst)
        !hit_found |-> trail_out == trail_in);

    a_r8_clear_needs_both: assert property (@(posedge clk) disable iff (rst)
        mrpn_clear |-> (hit_found && mrpn_valid));

    a_r9_desc_shift: assert property (@(posedge clk) disable iff (rst)
        (!ray_start && desc_step)
            |=> ovl_q[DEPTH-1:1] == $past(ovl_q[DEPTH-2:0]));
endmodule

bind tint_prune_unit tint_prune_checker #(.DEPTH(DEPTH), .LVW(LVW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ray_start  (ray_start),
    .desc_step  (desc_step),
    .desc_both  (desc_both),
    .back_step  (back_step),
    .back_levels(back_levels),
    .trail_in   (trail_in),
    .mrpn_valid (mrpn_valid),
    .hit_found  (hit_found),
    .trail_out  (trail_out),
    .mrpn_clear (mrpn_clear),
    .ovl_q      (ovl_q)
);

// File: tb/tint_prune_unit_bench.sv
module tint_prune_unit_bench;
    localparam int DEPTH = 32;
    localparam int TW    = 16;
    localparam int LVW   = $clog2(DEPTH + 1);
    localparam logic [DEPTH-1:0] ONES = '1;

    typedef struct {
        logic [DEPTH-1:0] exp_trail;
        logic             exp_clr;
        string            tag;
    } exp_item_t;

    logic             clk = 1'b0;
    logic             rst;
    logic             ray_start, desc_step, desc_both, back_step;
    logic [TW-1:0]    t_l_near, t_l_far, t_r_near, t_r_far;
    logic [LVW-1:0]   back_levels;
    logic [DEPTH-1:0] trail_in;
    logic             mrpn_valid, hit_found;
    logic [DEPTH-1:0] trail_out;
    logic             mrpn_clear;

    exp_item_t        sb[$];
    logic [DEPTH-1:0] model_ovl;
    int               n_checks = 0;
    int               n_bad    = 0;
    bit               finished = 0;

    always #4 clk = ~clk;

    tint_prune_unit #(.DEPTH(DEPTH), .TW(TW)) u_tint_prune_unit (
        .clk(clk), .rst(rst), .ray_start(ray_start), .desc_step(desc_step),
        .desc_both(desc_both), .t_l_near(t_l_near), .t_l_far(t_l_far),
        .t_r_near(t_r_near), .t_r_far(t_r_far), .back_step(back_step),
        .back_levels(back_levels), .trail_in(trail_in), .mrpn_valid(mrpn_valid),
        .hit_found(hit_found), .trail_out(trail_out), .mrpn_clear(mrpn_clear)
    );

    function automatic logic ivl_overlap(input logic [TW-1:0] a0, a1, b0, b1);
        return !((a1 < b0) || (b1 < a0));
    endfunction

    // Driver: applies one cycle of stimulus, predicts outputs, updates model
    task automatic step(input logic st, input logic dn, input logic both,
                        input logic [TW-1:0] l0, l1, r0, r1,
                        input logic bk, input logic [LVW-1:0] lv,
                        input logic [DEPTH-1:0] main, input logic mv,
                        input logic hit, input string tag);
        exp_item_t it;
        logic [DEPTH-1:0] lowb;
        @(negedge clk);
        ray_start = st; desc_step = dn; desc_both = both;
        t_l_near = l0; t_l_far = l1; t_r_near = r0; t_r_far = r1;
        back_step = bk; back_levels = lv; trail_in = main;
        mrpn_valid = mv; hit_found = hit;
        lowb = main & (-main);
        it.exp_trail = hit ? (main & model_ovl) : main;
        it.exp_clr   = hit && mv && ((lowb & model_ovl) == '0);
        it.tag       = tag;
        #1 sb.push_back(it);
        if (st)      model_ovl = '0;
        else if (dn) model_ovl = {model_ovl[DEPTH-2:0], both && ivl_overlap(l0, l1, r0, r1)};
        else if (bk) model_ovl = model_ovl >> lv;
    endtask

    task automatic idle_probe(input logic [DEPTH-1:0] main, input logic mv, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, main, mv, 1, tag);
    endtask

    task automatic descend(input logic both, input logic [TW-1:0] l0, l1, r0, r1, input string tag);
        step(0, 1, both, l0, l1, r0, r1, 0, 0, ONES, 0, 0, tag);
    endtask

    // Monitor: pops predictions and compares against the ports mid-cycle
    initial begin
        exp_item_t it;
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                n_checks++;
                if (trail_out !== it.exp_trail || mrpn_clear !== it.exp_clr) begin
                    n_bad++;
                    $display("FAIL %s: trail_out=%h mrpn_clear=%b expected trail_out=%h mrpn_clear=%b",
                             it.tag, trail_out, mrpn_clear, it.exp_trail, it.exp_clr);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        model_ovl = '0;
        rst = 1'b1;
        ray_start = 0; desc_step = 0; desc_both = 0; back_step = 0;
        t_l_near = 0; t_l_far = 0; t_r_near = 0; t_r_far = 0;
        back_levels = 0; trail_in = 0; mrpn_valid = 0; hit_found = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        idle_probe(ONES, 1, "R1 reset state");

        // R2 / R3: build pattern ...1001 from the top of a ray
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, ONES, 0, 0, "R5 start");
        descend(1, 16'd10, 16'd20, 16'd20, 16'd30, "R2 touching overlap");
        descend(1, 16'd10, 16'd19, 16'd20, 16'd30, "R2 disjoint left first");
        descend(0, 16'd10, 16'd40, 16'd20, 16'd30, "R3 single hit");
        descend(1, 16'd5,  16'd50, 16'd20, 16'd30, "R2 nested overlap");
        idle_probe(ONES, 0, "R2 R3 pattern 1001");
        descend(1, 16'd40, 16'd50, 16'd20, 16'd39, "R2 disjoint right first");
        idle_probe(ONES, 0, "R2 right-first stores 0");
        step(0, 0, 0, 0, 0, 0, 0, 1, 6'd1, ONES, 0, 0, "R4 back 1");

        // R6 / R7 / R8 with trail 1001
        idle_probe(32'h0000_0006, 1, "R7 lowest level pruned");
        idle_probe(32'h0000_0008, 1, "R7 lowest level kept");
        idle_probe(32'h0000_0000, 1, "R7 empty main trail");
        idle_probe(32'h0000_0006, 0, "R8 mrpn not valid");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0000_00F6, 1, 0, "R6 R8 no hit pass");

        // R4: multi-level backtrack
        step(0, 0, 0, 0, 0, 0, 0, 1, 6'd3, ONES, 0, 0, "R4 back 3");
        idle_probe(ONES, 0, "R4 after back 3");
        step(0, 0, 0, 0, 0, 0, 0, 1, 6'd1, ONES, 0, 0, "R4 back 1 to empty");
        idle_probe(ONES, 0, "R4 trail empty");

        // R5 precedence
        descend(1, 16'd1, 16'd9, 16'd2, 16'd8, "R5 setup");
        step(1, 1, 1, 16'd1, 16'd9, 16'd2, 16'd8, 1, 6'd1, ONES, 0, 0, "R5 start beats all");
        idle_probe(ONES, 0, "R5 cleared");
        descend(1, 16'd1, 16'd9, 16'd2, 16'd8, "R5 setup 2");
        step(0, 1, 1, 16'd1, 16'd9, 16'd2, 16'd8, 1, 6'd1, ONES, 0, 0, "R5 desc beats back");
        idle_probe(ONES, 0, "R5 desc won");

        // R6: hit in the same cycle as a descent uses pre-edge trail
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h0000_0003, 1, 1, "R6 hit with descent");
        idle_probe(ONES, 1, "R6 after descent");

        // R9: overflow past the depth, then full-depth backtrack
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, ONES, 0, 0, "R5 start");
        for (int i = 0; i < DEPTH + 1; i++)
            descend(1, 16'd3, 16'd7, 16'd4, 16'd9, "R9 fill");
        idle_probe(ONES, 1, "R9 saturated all ones");
        step(0, 0, 0, 0, 0, 0, 0, 1, 6'(DEPTH), ONES, 0, 0, "R4 full depth");
        idle_probe(ONES, 1, "R4 full depth empties");

        // Random mix against the model
        for (int i = 0; i < 2000; i++) begin
            int sel;
            logic [TW-1:0] a, b, c, d;
            sel = $urandom_range(0, 99);
            a = TW'($urandom_range(0, 15)); b = a + TW'($urandom_range(0, 8));
            c = TW'($urandom_range(0, 15)); d = c + TW'($urandom_range(0, 8));
            step(sel < 3, sel < 60, 1'($urandom_range(0, 1)), a, b, c, d,
                 sel >= 45, LVW'($urandom_range(0, 6)),
                 {$urandom(), $urandom()} >> $urandom_range(0, 31),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 "R2 R6 R7 random");
        end

        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule